// File: doc/BRIEF.md
# Command Queue Trigger Controller

This block decides when a single command queue may hand commands to a serial converter link. It holds the queue in one of three states: idle, waiting for a trigger, and triggered. While the queue is triggered and the link is free, the block asks the link for the next command. The start condition comes from one of three sources. In software mode it is a strobe. In edge mode it is a synchronized edge of an external pin, with the polarity selectable. In level mode the same pin acts as an active-low gate.

A trigger that arrives while the queue is already triggered is an overrun. It sets a sticky flag, and that flag can raise an interrupt request when the request is enabled. In level mode, a gate closure that happens during a command transfer is held back until the transfer ends. An overrun in level mode is a closure followed by a reopening inside one transfer. While the gate keeps the queue waiting, the block asks the link to send a null message.

Top module: `cmdq_trig_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `q_state` becomes 0 (idle) and `cmd_req`, `null_req`, `ovr_flag` and `irq` all become 0.
- R2: `mode` is encoded as 0 software, 1 edge, 2 level and 3 off. `q_state` is encoded as 0 idle, 1 waiting and 2 triggered. If `enable` is low, or `mode` is 3, or `mode` differs from its value at the previous edge, the next state is idle and `cmd_req` is 0; `ovr_flag` keeps its value. Otherwise, idle moves to waiting at the next edge.
- R3: In software mode, `sw_trig` in the waiting state moves the queue to triggered at the next edge. In the triggered state it is ignored. Software mode never sets `ovr_flag`.
- R4: In edge mode, `ext_trig` passes through a two-stage synchronizer. A rising edge, or a falling edge when `edge_fall` is 1, moves the waiting queue to triggered on the third clock edge after the pin changes. An edge of the unselected polarity has no effect.
- R5: In edge mode, a selected edge that arrives while the queue is triggered sets `ovr_flag`.
- R6: In software and edge modes, `link_done` in the triggered state returns the queue to waiting at the next edge. Each trigger therefore releases one command.
- R7: In level mode the gate is open while `ext_trig` is low. An open gate moves the waiting queue to triggered. A closed gate while `link_busy` is low returns the triggered queue to waiting. A closure while `link_busy` is high takes effect only at `link_done`.
- R8: In level mode, if the gate closes and then reopens while `link_busy` is high, `ovr_flag` is set. The queue stays triggered after that transfer's `link_done`.
- R9: `null_req` is 1 exactly in the cycle after an edge at which the queue, in level mode, enters or stays in waiting with `link_busy` low.
- R10: `cmd_req` is 1 exactly in the cycle after an edge at which the queue is triggered and `link_busy` was low. It is never 1 together with `null_req`.
- R11: `ovr_flag` stays set until an edge with `ovr_clr` high clears it. If a set and a clear fall on the same edge, the flag ends up set.
- R12: `irq` is 1 exactly when `ovr_flag` is 1 and `ovr_ie` was 1 at the edge that produced that flag value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Queue enable |
| mode | input | 2 | Trigger mode: 0 software, 1 edge, 2 level, 3 off |
| edge_fall | input | 1 | Edge mode: 1 selects falling edges |
| ext_trig | input | 1 | Asynchronous trigger pin or gate (gate open when low) |
| sw_trig | input | 1 | Software trigger strobe |
| ovr_ie | input | 1 | Overrun interrupt enable |
| ovr_clr | input | 1 | Overrun flag clear strobe |
| link_busy | input | 1 | Link is shifting a command |
| link_done | input | 1 | One-cycle strobe at the end of a transfer |
| q_state | output | 2 | Queue state: 0 idle, 1 waiting, 2 triggered |
| cmd_req | output | 1 | Request to send the next queued command |
| null_req | output | 1 | Request to send a null message |
| ovr_flag | output | 1 | Sticky trigger overrun flag |
| irq | output | 1 | Overrun interrupt request |

## Verification
The hardest case to reach is the level-mode overrun. The gate has to close and then reopen inside one transfer, and each pin change only arrives after the synchronizer stages. The stimulus holds `link_busy` high and moves `ext_trig` to closed. It waits three cycles and checks that the queue is still triggered, then reopens the gate. It then checks the flag before `link_done` and the state after it. The same-edge set and clear is reached by timing `ovr_clr` to the cycle in which a synchronized edge becomes visible.

// File: rtl/cmdq_trig_pkg.sv
package cmdq_trig_pkg;
  typedef enum logic [1:0] {
    MODE_SW    = 2'd0,
    MODE_EDGE  = 2'd1,
    MODE_LEVEL = 2'd2,
    MODE_OFF   = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_TRIG = 2'd2
  } q_state_e;
endpackage

// File: rtl/cmdq_trig_sync.sv
module cmdq_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign lvl  = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/cmdq_trig_fsm.sv
module cmdq_trig_fsm
  import cmdq_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  trig_mode_e mode,
  input  logic       sw_trig,
  input  logic       edge_evt,
  input  logic       gate_open,
  input  logic       link_busy,
  input  logic       link_done,
  output q_state_e   state,
  output logic       cmd_req,
  output logic       null_req,
  output logic       ovr_set
);
  trig_mode_e mode_q;
  q_state_e   nxt;
  logic       closed_seen, closed_nxt;
  logic       mode_ok;

  always_comb begin
    nxt        = state;
    closed_nxt = closed_seen;
    ovr_set    = 1'b0;
    mode_ok    = enable && (mode == mode_q) && (mode != MODE_OFF);
    if (!mode_ok) begin
      nxt        = ST_IDLE;
      closed_nxt = 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: nxt = ST_WAIT;
        ST_WAIT: begin
          closed_nxt = 1'b0;
          unique case (mode)
            MODE_SW:    if (sw_trig)   nxt = ST_TRIG;
            MODE_EDGE:  if (edge_evt)  nxt = ST_TRIG;
            MODE_LEVEL: if (gate_open) nxt = ST_TRIG;
            default:    nxt = ST_IDLE;
          endcase
        end
        ST_TRIG: begin
          unique case (mode)
            MODE_SW: if (link_done) nxt = ST_WAIT;
            MODE_EDGE: begin
              if (edge_evt)  ovr_set = 1'b1;
              if (link_done) nxt = ST_WAIT;
            end
            MODE_LEVEL: begin
              if (link_done) begin
                // deferred closure resolves at the end of the transfer
                if (closed_seen || !gate_open) nxt = ST_WAIT;
                closed_nxt = 1'b0;
              end else if (link_busy) begin
                if (!gate_open) closed_nxt = 1'b1;
                else if (closed_seen) begin
                  ovr_set    = 1'b1;
                  closed_nxt = 1'b0;
                end
              end else if (!gate_open) begin
                nxt = ST_WAIT;
              end
            end
            default: nxt = ST_IDLE;
          endcase
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_SW;
      state       <= ST_IDLE;
      closed_seen <= 1'b0;
      cmd_req     <= 1'b0;
      null_req    <= 1'b0;
    end else begin
      mode_q      <= mode;
      state       <= nxt;
      closed_seen <= closed_nxt;
      cmd_req     <= (nxt == ST_TRIG) && !link_busy;
      null_req    <= mode_ok && (mode == MODE_LEVEL) && (nxt == ST_WAIT) && !link_busy;
    end
  end
endmodule

// File: rtl/cmdq_trig_ovr.sv
module cmdq_trig_ovr (
  input  logic clk,
  input  logic rst,
  input  logic ovr_set,
  input  logic ovr_clr,
  input  logic ovr_ie,
  output logic ovr_flag,
  output logic irq
);
  logic flag_nxt;

  always_comb begin
    flag_nxt = ovr_flag;
    if (ovr_clr) flag_nxt = 1'b0;
    if (ovr_set) flag_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      ovr_flag <= flag_nxt;
      irq      <= flag_nxt & ovr_ie;
    end
  end
endmodule

// File: rtl/cmdq_trig_ctrl.sv
module cmdq_trig_ctrl
  import cmdq_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic [1:0] mode,
  input  logic       edge_fall,
  input  logic       ext_trig,
  input  logic       sw_trig,
  input  logic       ovr_ie,
  input  logic       ovr_clr,
  input  logic       link_busy,
  input  logic       link_done,
  output logic [1:0] q_state,
  output logic       cmd_req,
  output logic       null_req,
  output logic       ovr_flag,
  output logic       irq
);
  logic     pin_lvl, pin_rise, pin_fall;
  logic     edge_evt, ovr_set;
  q_state_e st;

  cmdq_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(ext_trig),
    .lvl(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  assign edge_evt = edge_fall ? pin_fall : pin_rise;

  cmdq_trig_fsm u_fsm (
    .clk(clk), .rst(rst), .enable(enable), .mode(trig_mode_e'(mode)),
    .sw_trig(sw_trig), .edge_evt(edge_evt), .gate_open(!pin_lvl),
    .link_busy(link_busy), .link_done(link_done),
    .state(st), .cmd_req(cmd_req), .null_req(null_req), .ovr_set(ovr_set)
  );

  cmdq_trig_ovr u_ovr (
    .clk(clk), .rst(rst), .ovr_set(ovr_set), .ovr_clr(ovr_clr),
    .ovr_ie(ovr_ie), .ovr_flag(ovr_flag), .irq(irq)
  );

  assign q_state = st;
endmodule

// File: rtl/cmdq_trig_ctrl_chk.sv
module cmdq_trig_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic [1:0] mode,
  input logic       link_busy,
  input logic       ovr_clr,
  input logic [1:0] q_state,
  input logic       cmd_req,
  input logic       null_req,
  input logic       ovr_flag,
  input logic       irq
);
  assert_req_only_trig_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_req |-> (q_state == 2'd2) && !$past(link_busy));

  assert_req_null_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_req, null_req}));

  assert_null_waiting_R9: assert property (@(posedge clk) disable iff (rst)
    null_req |-> (q_state == 2'd1) && !$past(link_busy));

  assert_disable_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> (q_state == 2'd0) && !cmd_req);

  assert_sw_no_overrun_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_flag) |-> ($past(mode) != 2'd0));

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(ovr_flag) |-> $past(ovr_clr));

  assert_irq_needs_flag_R12: assert property (@(posedge clk) disable iff (rst)
    irq |-> ovr_flag);
endmodule

bind cmdq_trig_ctrl cmdq_trig_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .enable(enable), .mode(mode), .link_busy(link_busy),
  .ovr_clr(ovr_clr), .q_state(q_state), .cmd_req(cmd_req),
  .null_req(null_req), .ovr_flag(ovr_flag), .irq(irq)
);

// File: tb/cmdq_trig_ctrl_bench.sv
module cmdq_trig_ctrl_bench;
  localparam int CLK_NS = 5;

  logic clk = 1'b0;
  logic rst = 1'b1, enable = 1'b0, edge_fall = 1'b0, ext_trig = 1'b0;
  logic sw_trig = 1'b0, ovr_ie = 1'b0, ovr_clr = 1'b0;
  logic link_busy = 1'b0, link_done = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [1:0] q_state;
  logic cmd_req, null_req, ovr_flag, irq;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #(CLK_NS / 2.0) clk = ~clk;

  cmdq_trig_ctrl u_cmdq_trig_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .mode(mode), .edge_fall(edge_fall),
    .ext_trig(ext_trig), .sw_trig(sw_trig), .ovr_ie(ovr_ie), .ovr_clr(ovr_clr),
    .link_busy(link_busy), .link_done(link_done), .q_state(q_state),
    .cmd_req(cmd_req), .null_req(null_req), .ovr_flag(ovr_flag), .irq(irq)
  );

  // {sw_trig, link_busy, link_done, exp_state[1:0], exp_cmd_req}, software mode
  localparam logic [5:0] VEC [8] = '{
    {3'b000, 2'd1, 1'b0},
    {3'b100, 2'd2, 1'b1},
    {3'b010, 2'd2, 1'b0},
    {3'b110, 2'd2, 1'b0},
    {3'b001, 2'd1, 1'b0},
    {3'b000, 2'd1, 1'b0},
    {3'b100, 2'd2, 1'b1},
    {3'b001, 2'd1, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    step(2);
    check("R1 state", q_state, 0);
    check("R1 cmd_req", cmd_req, 0);
    check("R1 null_req", null_req, 0);
    check("R1 flag", ovr_flag, 0);
    check("R1 irq", irq, 0);
    rst = 1'b0; enable = 1'b1;
    step(1);
    check("R2 idle to waiting", q_state, 1);

    for (int i = 0; i < 8; i++) begin
      sw_trig = VEC[i][5]; link_busy = VEC[i][4]; link_done = VEC[i][3];
      step(1);
      sw_trig = 1'b0; link_done = 1'b0;
      check("R3/R6/R10 vector state", q_state, int'(VEC[i][2:1]));
      check("R10 vector cmd_req", cmd_req, int'(VEC[i][0]));
      check("R3 no overrun in software mode", ovr_flag, 0);
    end

    // edge mode
    mode = 2'd1;
    step(1); check("R2 mode change idles", q_state, 0);
    step(1); check("R2 re-arm waiting", q_state, 1);
    ext_trig = 1'b1;
    step(2); check("R4 sync latency", q_state, 1);
    step(1); check("R4 rising edge triggers", q_state, 2);
    check("R10 cmd_req when free", cmd_req, 1);
    link_busy = 1'b1;
    step(1); check("R10 no cmd_req while busy", cmd_req, 0);
    ext_trig = 1'b0;
    step(3); check("R4 falling edge ignored", ovr_flag, 0);
    check("R4 still triggered", q_state, 2);
    ovr_ie = 1'b1; ext_trig = 1'b1;
    step(3); check("R5 edge overrun", ovr_flag, 1);
    check("R12 irq raised", irq, 1);
    step(2); check("R11 flag sticky", ovr_flag, 1);
    ovr_clr = 1'b1; step(1); ovr_clr = 1'b0;
    check("R11 flag cleared", ovr_flag, 0);
    check("R12 irq dropped", irq, 0);
    ext_trig = 1'b0; step(3);
    ext_trig = 1'b1; step(2);
    ovr_clr = 1'b1; step(1); ovr_clr = 1'b0;
    check("R11 set wins over clear", ovr_flag, 1);
    ovr_clr = 1'b1; step(1); ovr_clr = 1'b0;
    check("R11 clear again", ovr_flag, 0);
    link_busy = 1'b0; link_done = 1'b1; step(1); link_done = 1'b0;
    check("R6 done returns to waiting", q_state, 1);
    edge_fall = 1'b1; ext_trig = 1'b0;
    step(3); check("R4 falling edge selected", q_state, 2);
    ext_trig = 1'b1; step(3);
    ext_trig = 1'b0; step(3);
    check("R5 falling overrun", ovr_flag, 1);

    // level mode, gate closed (ext_trig high)
    mode = 2'd2; ext_trig = 1'b1;
    step(1); check("R2 mode change idles", q_state, 0);
    check("R2 flag kept", ovr_flag, 1);
    check("R2 no cmd_req", cmd_req, 0);
    step(3); check("R7 closed gate waits", q_state, 1);
    check("R9 null message", null_req, 1);
    ovr_clr = 1'b1; step(1); ovr_clr = 1'b0;
    ext_trig = 1'b0;
    step(3); check("R7 gate opens", q_state, 2);
    check("R10 cmd_req in level", cmd_req, 1);
    check("R9 no null when triggered", null_req, 0);
    link_busy = 1'b1; step(1);
    ext_trig = 1'b1;
    step(4); check("R7 closure deferred", q_state, 2);
    link_busy = 1'b0; link_done = 1'b1; step(1); link_done = 1'b0;
    check("R7 closure at done", q_state, 1);
    check("R9 null after closure", null_req, 1);
    ext_trig = 1'b0;
    step(3); check("R7 reopen triggers", q_state, 2);
    link_busy = 1'b1; ext_trig = 1'b1;
    step(3); check("R8 no flag on close only", ovr_flag, 0);
    ext_trig = 1'b0;
    step(3); check("R8 close-reopen overrun", ovr_flag, 1);
    check("R12 irq level", irq, 1);
    link_busy = 1'b0; link_done = 1'b1; step(1); link_done = 1'b0;
    check("R8 stays triggered", q_state, 2);
    check("R10 next command", cmd_req, 1);
    ext_trig = 1'b1;
    step(3); check("R7 close while link free", q_state, 1);

    enable = 1'b0;
    step(1); check("R2 disable idles", q_state, 0);
    check("R2 disable keeps flag", ovr_flag, 1);
    check("R9 no null when idle", null_req, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule